// File: doc/BRIEF.md
# Single-Level Interrupt Arbiter

This block decides which of two interrupt sources a small microcontroller core services next. One source is an external, active-low request pin. The other is the overflow pulse of an internal timer. Each source has its own enable that the core sets and clears with one-cycle command strobes. When a request is accepted, the block raises a one-cycle call request toward the core, together with a 12-bit vector: 3 for the external source and 7 for the timer.

Nesting is single-level. After any acceptance, every further request is held off until the core executes its return-and-restore instruction, which it signals with a strobe that stays high for the two cycles of that instruction. Acceptance opens again from the second of those cycles. The timer request is kept in a pending latch, so it survives while the external interrupt is being serviced. The external request is a level, so a pin still held low at the return is taken again at once. The synchronized pin level is also brought out, so the core can poll it as a plain test input.

Top module: `irq_arbiter`

## Requirements
- R1: After reset both enables are clear, `call_req` is 0 and `call_vec` is 0; a low external pin produces no call.
- R2: With the external enable set, a low `ext_irq_n` gives a call with vector 3 on the third rising edge after the pin falls (two synchronizer flops, then one output register).
- R3: With the timer enable set, a one-cycle `tmr_ovf` gives a call with vector 7 on the second rising edge after it (pending latch, then output register).
- R4: When the external and timer requests are valid in the same cycle, vector 3 is issued; the timer stays pending and is called with vector 7 after the following return.
- R5: After any call, no further call is issued, whatever the requests, until a return strobe arrives.
- R6: The return strobe `ret_busy` is high for two consecutive cycles. A waiting request is called on the rising edge that ends the second cycle, never on the one that ends the first.
- R7: An external pin still low when acceptance reopens is accepted again with vector 3.
- R8: `ext_level` follows the synchronized pin (1 = high) whether or not the external enable is set.
- R9: Clearing the timer enable discards a pending timer request. A `tmr_ovf` pulse while the timer enable is clear is ignored, and no call follows.
- R10: `call_req` is high for exactly one cycle per acceptance; `call_vec` is valid in that cycle and 0 in every other cycle.
- R11: With the external enable clear, a low pin produces no call.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_n | input | 1 | External request pin, active low, asynchronous |
| ext_en_set | input | 1 | One-cycle command: enable the external source |
| ext_en_clr | input | 1 | One-cycle command: disable the external source (wins over set) |
| tmr_en_set | input | 1 | One-cycle command: enable the timer source |
| tmr_en_clr | input | 1 | One-cycle command: disable the timer source and drop its pending request |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| ret_busy | input | 1 | High during both cycles of the return-and-restore instruction |
| call_req | output | 1 | One-cycle call request to the core |
| call_vec | output | 12 | Vector address, valid while call_req is high, otherwise 0 |
| ext_level | output | 1 | Synchronized level of the external pin |

## Verification
The hardest situation to reach is a genuine tie, in which the external and timer requests become valid in the very same cycle. The external request only reaches the arbiter two flops after the pin moves, while the timer request takes one cycle through its latch. The bench therefore drives the pin low and pulses the overflow exactly one cycle later. It then checks the vector 3 call, the silent lockout while the timer waits, and the vector 7 call on the second return cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int unsigned VEC_W_DEF   = 12;
    localparam int unsigned EXT_VEC_DEF = 3;
    localparam int unsigned TMR_VEC_DEF = 7;

    // enable and pending state of the two sources
    typedef struct packed {
        logic ext_en;
        logic tmr_en;
        logic tmr_pend;
    } src_state_t;

endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchronizer for an asynchronous level input.
module irq_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_d;
    logic [LAST:0] chain_q;

    always_comb begin
        chain_d = {chain_q[LAST-1:0], d};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[LAST];
endmodule

// File: rtl/irq_src_ctrl.sv
// Per-source enables and the timer pending latch.
module irq_src_ctrl
    import irq_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_active,
    input  logic ext_en_set,
    input  logic ext_en_clr,
    input  logic tmr_en_set,
    input  logic tmr_en_clr,
    input  logic tmr_ovf,
    input  logic tmr_take,
    output logic ext_req,
    output logic tmr_req,
    output logic tmr_pend
);
    src_state_t st_d;
    src_state_t st_q;

    always_comb begin
        st_d = st_q;

        // external enable: disable has priority
        if (ext_en_clr) begin
            st_d.ext_en = 1'b0;
        end else if (ext_en_set) begin
            st_d.ext_en = 1'b1;
        end

        // timer enable: disable has priority
        if (tmr_en_clr) begin
            st_d.tmr_en = 1'b0;
        end else if (tmr_en_set) begin
            st_d.tmr_en = 1'b1;
        end

        // pending latch: drop on disable, set on overflow, clear on accept
        if (tmr_en_clr) begin
            st_d.tmr_pend = 1'b0;
        end else if (tmr_ovf && st_q.tmr_en) begin
            st_d.tmr_pend = 1'b1;
        end else if (tmr_take) begin
            st_d.tmr_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ext_req  = st_q.ext_en & ext_active;
    assign tmr_req  = st_q.tmr_en & st_q.tmr_pend;
    assign tmr_pend = st_q.tmr_pend;
endmodule

// File: rtl/irq_priority.sv
// Fixed-priority selection: external before timer.
module irq_priority #(
    parameter int unsigned VEC_W   = 12,
    parameter int unsigned EXT_VEC = 3,
    parameter int unsigned TMR_VEC = 7
) (
    input  logic             allow,
    input  logic             ext_req,
    input  logic             tmr_req,
    output logic             take,
    output logic             take_tmr,
    output logic [VEC_W-1:0] vec
);
    localparam logic [VEC_W-1:0] EXT_V = VEC_W'(EXT_VEC);
    localparam logic [VEC_W-1:0] TMR_V = VEC_W'(TMR_VEC);

    always_comb begin
        take     = 1'b0;
        take_tmr = 1'b0;
        vec      = '0;
        if (allow) begin
            if (ext_req) begin
                take = 1'b1;
                vec  = EXT_V;
            end else if (tmr_req) begin
                take     = 1'b1;
                take_tmr = 1'b1;
                vec      = TMR_V;
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned VEC_W       = VEC_W_DEF,
    parameter int unsigned EXT_VEC     = EXT_VEC_DEF,
    parameter int unsigned TMR_VEC     = TMR_VEC_DEF,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_irq_n,
    input  logic             ext_en_set,
    input  logic             ext_en_clr,
    input  logic             tmr_en_set,
    input  logic             tmr_en_clr,
    input  logic             tmr_ovf,
    input  logic             ret_busy,
    output logic             call_req,
    output logic [VEC_W-1:0] call_vec,
    output logic             ext_level
);
    typedef struct packed {
        logic             lock;
        logic             ret_prev;
        logic             call;
        logic [VEC_W-1:0] vec;
    } arb_state_t;

    arb_state_t st_d;
    arb_state_t st_q;

    logic             pin_sync;
    logic             ext_req;
    logic             tmr_req;
    logic             tmr_pend;
    logic             take;
    logic             take_tmr;
    logic [VEC_W-1:0] sel_vec;
    logic             ret_first;

    irq_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_irq_n),
        .q     (pin_sync)
    );

    irq_src_ctrl u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_active (~pin_sync),
        .ext_en_set (ext_en_set),
        .ext_en_clr (ext_en_clr),
        .tmr_en_set (tmr_en_set),
        .tmr_en_clr (tmr_en_clr),
        .tmr_ovf    (tmr_ovf),
        .tmr_take   (take_tmr),
        .ext_req    (ext_req),
        .tmr_req    (tmr_req),
        .tmr_pend   (tmr_pend)
    );

    irq_priority #(
        .VEC_W   (VEC_W),
        .EXT_VEC (EXT_VEC),
        .TMR_VEC (TMR_VEC)
    ) u_prio (
        .allow    (~st_q.lock),
        .ext_req  (ext_req),
        .tmr_req  (tmr_req),
        .take     (take),
        .take_tmr (take_tmr),
        .vec      (sel_vec)
    );

    // first cycle of the return instruction; lock drops at its closing edge
    assign ret_first = ret_busy & ~st_q.ret_prev;

    always_comb begin
        st_d          = st_q;
        st_d.ret_prev = ret_busy;
        st_d.call     = take;
        st_d.vec      = sel_vec;
        if (take) begin
            st_d.lock = 1'b1;
        end else if (ret_first) begin
            st_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign call_req  = st_q.call;
    assign call_vec  = st_q.vec;
    assign ext_level = pin_sync;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int unsigned VEC_W   = 12,
    parameter int unsigned EXT_VEC = 3,
    parameter int unsigned TMR_VEC = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             call_req,
    input logic [VEC_W-1:0] call_vec,
    input logic             lock,
    input logic             ext_req,
    input logic             tmr_pend,
    input logic             tmr_ovf
);
    localparam logic [VEC_W-1:0] EXT_V = VEC_W'(EXT_VEC);
    localparam logic [VEC_W-1:0] TMR_V = VEC_W'(TMR_VEC);

    a_r10_one_cycle_call: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> !call_req);

    a_r10_vec_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !call_req |-> call_vec == '0);

    a_r2_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (call_vec == EXT_V || call_vec == TMR_V));

    a_r5_lock_after_call: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> lock);

    a_r4_ext_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && call_vec == TMR_V) |-> !$past(ext_req));

    a_r3_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && call_vec == TMR_V) |-> (!tmr_pend || $past(tmr_ovf)));
endmodule

bind irq_arbiter irq_arbiter_chk #(
    .VEC_W   (VEC_W),
    .EXT_VEC (EXT_VEC),
    .TMR_VEC (TMR_VEC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_req (call_req),
    .call_vec (call_vec),
    .lock     (st_q.lock),
    .ext_req  (ext_req),
    .tmr_pend (tmr_pend),
    .tmr_ovf  (tmr_ovf)
);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 12;
    localparam logic [VW-1:0] V_EXT = 12'd3;
    localparam logic [VW-1:0] V_TMR = 12'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_irq_n = 1'b1;
    logic          ext_en_set = 1'b0;
    logic          ext_en_clr = 1'b0;
    logic          tmr_en_set = 1'b0;
    logic          tmr_en_clr = 1'b0;
    logic          tmr_ovf = 1'b0;
    logic          ret_busy = 1'b0;
    logic          call_req;
    logic [VW-1:0] call_vec;
    logic          ext_level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_arbiter u_irq_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_irq_n  (ext_irq_n),
        .ext_en_set (ext_en_set),
        .ext_en_clr (ext_en_clr),
        .tmr_en_set (tmr_en_set),
        .tmr_en_clr (tmr_en_clr),
        .tmr_ovf    (tmr_ovf),
        .ret_busy   (ret_busy),
        .call_req   (call_req),
        .call_vec   (call_vec),
        .ext_level  (ext_level)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_cmd(ref logic sig);
        sig = 1'b1;
        tick();
        sig = 1'b0;
    endtask

    // expects no call during n sampled cycles
    task automatic quiet(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (call_req) seen++;
        end
        check(req, seen, 0);
    endtask

    // two-cycle return strobe with no expected call
    task automatic do_return();
        ret_busy = 1'b1;
        tick();
        if (call_req) check("R6 early call", 1, 0);
        tick();
        ret_busy = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 call after reset", call_req, 0);
        check("R1 vec after reset", call_vec, 0);
        ext_irq_n = 1'b0;
        quiet("R1 ext disabled at reset", 6);
        check("R8 level low while disabled", ext_level, 0);
        ext_irq_n = 1'b1;
        tick(3);
        check("R8 level high", ext_level, 1);
    endtask

    task automatic t_ext();
        pulse_cmd(ext_en_set);
        ext_irq_n = 1'b0;
        tick();
        check("R2 no call after edge 1", call_req, 0);
        tick();
        check("R2 no call after edge 2", call_req, 0);
        tick();
        check("R2 call after edge 3", call_req, 1);
        check("R2 vector 3", call_vec, V_EXT);
        tick();
        check("R10 call one cycle", call_req, 0);
        check("R10 vec idle zero", call_vec, 0);
        quiet("R5 lockout while pin low", 5);
        ext_irq_n = 1'b1;
        tick(3);
        do_return();
        quiet("R6 no call with nothing pending", 3);
    endtask

    task automatic t_level();
        ext_irq_n = 1'b0;
        tick(3);
        check("R7 first call", call_req, 1);
        tick(2);
        ret_busy = 1'b1;
        tick();
        check("R6 not on first return cycle", call_req, 0);
        tick();
        ret_busy = 1'b0;
        check("R7 re-accept at second return cycle", call_req, 1);
        check("R7 vector 3", call_vec, V_EXT);
        ext_irq_n = 1'b1;
        tick(3);
        do_return();
        tick(2);
    endtask

    task automatic t_timer();
        pulse_cmd(tmr_en_set);
        tmr_ovf = 1'b1;
        tick();
        tmr_ovf = 1'b0;
        check("R3 no call after edge 1", call_req, 0);
        tick();
        check("R3 call after edge 2", call_req, 1);
        check("R3 vector 7", call_vec, V_TMR);
        quiet("R3 latch cleared on accept", 3);
        do_return();
        quiet("R3 no repeat after return", 4);
    endtask

    task automatic t_tie();
        ext_irq_n = 1'b0;
        tick();
        tmr_ovf = 1'b1;
        tick();
        tmr_ovf = 1'b0;
        tick();
        check("R4 tie call", call_req, 1);
        check("R4 external wins", call_vec, V_EXT);
        ext_irq_n = 1'b1;
        quiet("R4 timer held while locked", 5);
        ret_busy = 1'b1;
        tick();
        check("R4 not on first return cycle", call_req, 0);
        tick();
        ret_busy = 1'b0;
        check("R4 pending timer called", call_req, 1);
        check("R4 vector 7", call_vec, V_TMR);
        tick();
        do_return();
        quiet("R4 nothing left", 3);
    endtask

    task automatic t_tmr_disable();
        ext_irq_n = 1'b0;
        tick(3);
        check("R9 ext call to lock", call_req, 1);
        ext_irq_n = 1'b1;
        tmr_ovf = 1'b1;
        tick();
        tmr_ovf = 1'b0;
        pulse_cmd(tmr_en_clr);
        tick(2);
        do_return();
        quiet("R9 pending dropped by disable", 4);
        tmr_ovf = 1'b1;
        tick();
        tmr_ovf = 1'b0;
        quiet("R9 overflow ignored when disabled", 4);
        pulse_cmd(tmr_en_set);
        quiet("R9 no stale request on re-enable", 4);
    endtask

    task automatic t_ext_disable();
        pulse_cmd(ext_en_clr);
        ext_irq_n = 1'b0;
        quiet("R11 ext masked", 6);
        check("R8 level readable when masked", ext_level, 0);
        ext_irq_n = 1'b1;
        tick(3);
        check("R8 level back high", ext_level, 1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_ext();
        t_level();
        t_timer();
        t_tie();
        t_tmr_disable();
        t_ext_disable();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule